// File: doc/BRIEF.md
# Stack and Interrupt-Entry Sequencer

This block owns a 16-bit stack pointer and turns one request into a short run of single-byte accesses on a byte-wide memory port. It supports six operations: push of one byte, push of a 16-bit word, pull of one byte, pull of a word, pull of a status byte, and an interrupt-entry sequence. Interrupt entry stores a return frame on the stack and then fetches a new 16-bit program counter from a vector address.

A mode input selects between a native mode, where the pointer moves through the full 16-bit space, and a legacy mode. In legacy mode the pointer is held inside page 0x01 and only its low byte wraps. The mode, the operation and all operand inputs are captured when a request is accepted. The block then runs one memory access per clock with `mem_req` held high, and ends with a one-cycle `done` pulse. At that point `sp`, `pull_data` and `status_out` hold the results.

Top module: `stkseq_top`

## Requirements
- R1: After reset `sp` is 0x01FF and `busy`, `done` and `mem_req` are low.
- R2: A byte push (op code 0) writes `push_data[7:0]` at the current pointer and leaves the pointer one lower.
- R3: A byte pull (op code 1) first raises the pointer by one, then reads at the raised address and returns the byte in `pull_data[7:0]` with `pull_data[15:8]` zero.
- R4: A word push (op code 2) writes the high byte first and the low byte second, on consecutive descending addresses. A word pull (op code 3) reads the low byte first and the high byte second. Each moves the pointer by two.
- R5: With `legacy` high, every stack access address and the pointer after every step have high byte 0x01, and the low byte wraps modulo 256. A pull at 0x01FF reads 0x0100, and a push at 0x0100 leaves 0x01FF.
- R6: With `legacy` low, the pointer carries across pages. A push at 0x0100 writes 0x0100 and leaves 0x00FF.
- R7: Interrupt entry (op code 5) in legacy mode writes three bytes: the high byte of `pc_in`+1, its low byte, then `status_in` with bit 5 set.
- R8: Interrupt entry in native mode writes four bytes: `bank_in`, the high byte of `pc_in`+1, its low byte, then `status_in` unchanged.
- R9: After the frame, interrupt entry reads the vector low byte at `vector_addr` and the high byte at `vector_addr`+1, and returns them as `pull_data`. `status_out` becomes `status_in` with bit 2 (interrupt disable) set and bit 3 (decimal) cleared.
- R10: A status pull (op code 4) performs a byte pull and returns the byte on `status_out`. In legacy mode bits 4 and 5 of the result are forced to 1; in native mode the byte is returned unchanged.
- R11: An accepted request produces exactly one memory access per cycle, with `mem_req` high from the cycle after acceptance until the last access. `done` is high for exactly one cycle, the cycle after the last access.
- R12: A `start` while `busy` is high, and a `start` with op code 6 or 7, cause no memory access and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| op | input | 3 | Operation code (0..5 valid) |
| legacy | input | 1 | 1 selects the one-page stack mode |
| push_data | input | 16 | Value for byte/word push |
| pc_in | input | 16 | Program counter for interrupt entry |
| bank_in | input | 8 | Program bank byte for native interrupt frame |
| status_in | input | 8 | Status byte for interrupt entry |
| vector_addr | input | 16 | Address of the interrupt vector low byte |
| mem_rdata | input | 8 | Read data, valid in the access cycle |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_req | output | 1 | Access strobe, one access per cycle |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pull_data | output | 16 | Pulled value or fetched vector |
| status_out | output | 8 | Pulled or updated status byte |

## Verification
A wrong pointer step or a mis-forced page byte shows up on `mem_addr` at the first access of the next operation. It also shows on `sp` in the `done` cycle of the same operation. A wrong step sequence shows as a misordered or missing write in the memory image and as a wrong access count. Both are visible before the next request. Checking every operation against a shadow stack model catches these faults within one sequence. Legacy-page forcing is examined at the wrap points 0x0100 and 0x01FF.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

    typedef enum logic [2:0] {
        OP_PUSH_B = 3'd0,
        OP_PULL_B = 3'd1,
        OP_PUSH_W = 3'd2,
        OP_PULL_W = 3'd3,
        OP_PULL_P = 3'd4,
        OP_IRQ    = 3'd5
    } op_e;

    localparam logic [2:0] OP_LAST = 3'd5;

    typedef enum logic [1:0] {
        K_PUSH = 2'd0,
        K_PULL = 2'd1,
        K_VEC  = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        S_LO   = 3'd0,
        S_HI   = 3'd1,
        S_BANK = 3'd2,
        S_PCH  = 3'd3,
        S_PCL  = 3'd4,
        S_STAT = 3'd5
    } src_e;

    typedef struct packed {
        kind_e kind;
        src_e  src;
        logic  hi_dst;
        logic  last;
    } uop_t;

    // status bit positions
    localparam int ST_IRQ_OFF = 2;
    localparam int ST_DEC     = 3;
    localparam int ST_XW      = 4;
    localparam int ST_MW      = 5;

endpackage

// File: rtl/stkseq_step.sv
module stkseq_step
    import stkseq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  op_e               op,
    input  logic [STEP_W-1:0] step,
    output uop_t              uop
);
    always_comb begin
        uop = '{kind: K_PUSH, src: S_LO, hi_dst: 1'b0, last: 1'b1};
        unique case (op)
            OP_PUSH_B: uop = '{kind: K_PUSH, src: S_LO, hi_dst: 1'b0, last: 1'b1};
            OP_PUSH_W: begin
                if (step == '0) uop = '{kind: K_PUSH, src: S_HI, hi_dst: 1'b0, last: 1'b0};
                else            uop = '{kind: K_PUSH, src: S_LO, hi_dst: 1'b0, last: 1'b1};
            end
            OP_PULL_B, OP_PULL_P:
                uop = '{kind: K_PULL, src: S_LO, hi_dst: 1'b0, last: 1'b1};
            OP_PULL_W: begin
                if (step == '0) uop = '{kind: K_PULL, src: S_LO, hi_dst: 1'b0, last: 1'b0};
                else            uop = '{kind: K_PULL, src: S_LO, hi_dst: 1'b1, last: 1'b1};
            end
            OP_IRQ: begin
                case (step)
                    3'd0:    uop = '{kind: K_PUSH, src: S_BANK, hi_dst: 1'b0, last: 1'b0};
                    3'd1:    uop = '{kind: K_PUSH, src: S_PCH,  hi_dst: 1'b0, last: 1'b0};
                    3'd2:    uop = '{kind: K_PUSH, src: S_PCL,  hi_dst: 1'b0, last: 1'b0};
                    3'd3:    uop = '{kind: K_PUSH, src: S_STAT, hi_dst: 1'b0, last: 1'b0};
                    3'd4:    uop = '{kind: K_VEC,  src: S_LO,   hi_dst: 1'b0, last: 1'b0};
                    default: uop = '{kind: K_VEC,  src: S_LO,   hi_dst: 1'b1, last: 1'b1};
                endcase
            end
            default: uop = '{kind: K_PUSH, src: S_LO, hi_dst: 1'b0, last: 1'b1};
        endcase
    end
endmodule

// File: rtl/stkseq_sp.sv
module stkseq_sp #(
    parameter int         ADDR_W      = 16,
    parameter logic [7:0] LEGACY_PAGE = 8'h01
) (
    input  logic [ADDR_W-1:0] sp,
    input  logic              legacy,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] push_next,
    output logic [ADDR_W-1:0] pull_next
);
    localparam int HI_W = ADDR_W - 8;

    logic [7:0] lo_dec, lo_inc;
    logic [HI_W-1:0] page;

    assign lo_dec = sp[7:0] - 8'd1;
    assign lo_inc = sp[7:0] + 8'd1;
    assign page   = HI_W'(LEGACY_PAGE);

    always_comb begin
        if (legacy) begin
            push_addr = {page, sp[7:0]};
            push_next = {page, lo_dec};
            pull_next = {page, lo_inc};
        end else begin
            push_addr = sp;
            push_next = sp - ADDR_W'(1);
            pull_next = sp + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/stkseq_top.sv
module stkseq_top
    import stkseq_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_SP    = 16'h01FF,
    parameter logic [7:0]        LEGACY_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              legacy,
    input  logic [15:0]       push_data,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [7:0]        bank_in,
    input  logic [7:0]        status_in,
    input  logic [ADDR_W-1:0] vector_addr,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_req,
    output logic [ADDR_W-1:0] sp,
    output logic              busy,
    output logic              done,
    output logic [15:0]       pull_data,
    output logic [7:0]        status_out
);
    localparam int STEP_W = 3;

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic              legacy;
        logic [STEP_W-1:0] step;
        logic [ADDR_W-1:0] sp;
        logic [15:0]       data;
        logic [ADDR_W-1:0] pc1;
        logic [7:0]        bank;
        logic [7:0]        stat;
        logic [ADDR_W-1:0] vec;
        logic [15:0]       result;
        logic [7:0]        stat_out;
        logic              done;
    } state_t;

    state_t state_d, state_q;
    uop_t   uop;
    logic [ADDR_W-1:0] push_addr, push_next, pull_next;
    logic [7:0] src_byte;

    stkseq_step #(.STEP_W(STEP_W)) u_step (
        .op  (state_q.op),
        .step(state_q.step),
        .uop (uop)
    );

    stkseq_sp #(.ADDR_W(ADDR_W), .LEGACY_PAGE(LEGACY_PAGE)) u_sp (
        .sp       (state_q.sp),
        .legacy   (state_q.legacy),
        .push_addr(push_addr),
        .push_next(push_next),
        .pull_next(pull_next)
    );

    always_comb begin
        unique case (uop.src)
            S_HI:    src_byte = state_q.data[15:8];
            S_BANK:  src_byte = state_q.bank;
            S_PCH:   src_byte = state_q.pc1[15:8];
            S_PCL:   src_byte = state_q.pc1[7:0];
            S_STAT:  src_byte = state_q.legacy ? (state_q.stat | 8'h20) : state_q.stat;
            default: src_byte = state_q.data[7:0];
        endcase
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;

        mem_req   = state_q.busy;
        mem_we    = state_q.busy && (uop.kind == K_PUSH);
        mem_wdata = src_byte;
        unique case (uop.kind)
            K_PULL:  mem_addr = pull_next;
            K_VEC:   mem_addr = state_q.vec + ADDR_W'(uop.hi_dst);
            default: mem_addr = push_addr;
        endcase

        if (!state_q.busy) begin
            if (start && (op <= OP_LAST)) begin
                state_d.busy   = 1'b1;
                state_d.op     = op_e'(op);
                state_d.legacy = legacy;
                state_d.step   = (op_e'(op) == OP_IRQ && legacy) ? STEP_W'(1) : '0;
                state_d.data   = push_data;
                state_d.pc1    = pc_in + ADDR_W'(1);
                state_d.bank   = bank_in;
                state_d.stat   = status_in;
                state_d.vec    = vector_addr;
                state_d.result = '0;
            end
        end else begin
            unique case (uop.kind)
                K_PUSH: state_d.sp = push_next;
                K_PULL: begin
                    state_d.sp = pull_next;
                    if (uop.hi_dst) state_d.result[15:8] = mem_rdata;
                    else            state_d.result[7:0]  = mem_rdata;
                    if (state_q.op == OP_PULL_P)
                        state_d.stat_out = state_q.legacy ? (mem_rdata | 8'h30) : mem_rdata;
                end
                default: begin
                    if (uop.hi_dst) state_d.result[15:8] = mem_rdata;
                    else            state_d.result[7:0]  = mem_rdata;
                end
            endcase
            state_d.step = state_q.step + STEP_W'(1);
            if (uop.last) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
                if (state_q.op == OP_IRQ) begin
                    state_d.stat_out = state_q.stat;
                    state_d.stat_out[ST_IRQ_OFF] = 1'b1;
                    state_d.stat_out[ST_DEC]     = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.op       <= OP_PUSH_B;
            state_q.legacy   <= 1'b1;
            state_q.sp       <= RESET_SP;
        end else begin
            state_q <= state_d;
        end
    end

    assign sp         = state_q.sp;
    assign busy       = state_q.busy;
    assign done       = state_q.done;
    assign pull_data  = state_q.result;
    assign status_out = state_q.stat_out;

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk
    import stkseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_req,
    input logic [ADDR_W-1:0] sp,
    input logic              done,
    input logic [7:0]        status_out,
    input logic              lat_legacy,
    input op_e               lat_op
);
    p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[7:0] == sp[7:0]));

    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (sp[7:0] == $past(sp[7:0]) - 8'd1));

    p_legacy_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && lat_legacy && lat_op != OP_IRQ) |-> (mem_addr[15:8] == 8'h01));

    p_legacy_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_legacy) |-> (sp[15:8] == 8'h01));

    p_irq_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_op == OP_IRQ) |-> (status_out[ST_IRQ_OFF] && !status_out[ST_DEC]));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(start));

    p_sp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> $stable(sp));
endmodule

bind stkseq_top stkseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_req   (mem_req),
    .sp        (sp),
    .done      (done),
    .status_out(status_out),
    .lat_legacy(state_q.legacy),
    .lat_op    (state_q.op)
);

// File: tb/test_stkseq_top.sv
module test_stkseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_i = '0;
    logic        legacy = 1'b1;
    logic [15:0] push_data = '0, pc_in = '0, vector_addr = '0;
    logic [7:0]  bank_in = '0, status_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, sp, pull_data;
    logic [7:0]  mem_wdata, status_out;
    logic        mem_we, mem_req, busy, done;

    always #5 clk = ~clk;

    stkseq_top i_stkseq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .legacy(legacy),
        .push_data(push_data), .pc_in(pc_in), .bank_in(bank_in),
        .status_in(status_in), .vector_addr(vector_addr), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_req(mem_req), .sp(sp), .busy(busy), .done(done),
        .pull_data(pull_data), .status_out(status_out)
    );

    // memory model with write log and access counter
    logic [7:0]  mem [0:4095];
    logic [15:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];
    int wcnt = 0;
    int acc  = 0;

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4096; k++) mem[k] <= 8'((k * 37 + 11) ^ (k >> 4));
        end else if (mem_req) begin
            acc <= acc + 1;
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                wlog_a[wcnt % 16]   <= mem_addr;
                wlog_d[wcnt % 16]   <= mem_wdata;
                wcnt <= wcnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // shadow model
    logic [15:0] exp_sp = 16'h01FF;
    logic [15:0] e_a [0:7];
    logic [7:0]  e_d [0:7];
    int e_n;

    task automatic m_push(input logic leg, input logic [7:0] b);
        e_a[e_n] = leg ? {8'h01, exp_sp[7:0]} : exp_sp;
        e_d[e_n] = b;
        e_n++;
        exp_sp = leg ? {8'h01, exp_sp[7:0] - 8'd1} : exp_sp - 16'd1;
    endtask

    task automatic m_pull(input logic leg, output logic [7:0] b);
        exp_sp = leg ? {8'h01, exp_sp[7:0] + 8'd1} : exp_sp + 16'd1;
        b = mem[exp_sp[11:0]];
    endtask

    task automatic run_op(input string rq, input logic [2:0] o, input logic leg,
                          input logic [15:0] d, input logic [15:0] pc,
                          input logic [7:0] bk, input logic [7:0] st,
                          input logic [15:0] vc, input logic poke);
        logic [7:0] b0, b1;
        logic [15:0] pcp, exp_res;
        logic [7:0] exp_st;
        logic chk_res, chk_st;
        int n_rd, base_w, base_a, guard;
        e_n = 0; n_rd = 0; chk_res = 0; chk_st = 0;
        exp_res = '0; exp_st = '0;
        case (o)
            3'd0: m_push(leg, d[7:0]);
            3'd2: begin m_push(leg, d[15:8]); m_push(leg, d[7:0]); end
            3'd1: begin m_pull(leg, b0); n_rd = 1; exp_res = {8'h00, b0}; chk_res = 1; end
            3'd3: begin m_pull(leg, b0); m_pull(leg, b1); n_rd = 2; exp_res = {b1, b0}; chk_res = 1; end
            3'd4: begin m_pull(leg, b0); n_rd = 1; exp_st = leg ? (b0 | 8'h30) : b0; chk_st = 1; end
            default: begin
                pcp = pc + 16'd1;
                if (!leg) m_push(leg, bk);
                m_push(leg, pcp[15:8]);
                m_push(leg, pcp[7:0]);
                m_push(leg, leg ? (st | 8'h20) : st);
                n_rd = 2;
                exp_res = {mem[(vc + 16'd1) & 16'h0FFF], mem[vc[11:0]]};
                exp_st = (st | 8'h04) & ~8'h08;
                chk_res = 1; chk_st = 1;
            end
        endcase
        @(negedge clk);
        base_w = wcnt; base_a = acc;
        start = 1'b1; op_i = o; legacy = leg; push_data = d; pc_in = pc;
        bank_in = bk; status_in = st; vector_addr = vc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1; op_i = 3'd0; legacy = ~leg; push_data = 16'hEEEE;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        chk(rq, "done seen", {31'd0, done}, 32'd1);
        chk(rq, "sp", {16'd0, sp}, {16'd0, exp_sp});
        chk("R11", "access count", acc - base_a, e_n + n_rd);
        chk(rq, "write count", wcnt - base_w, e_n);
        for (int i = 0; i < e_n; i++) begin
            chk(rq, "write addr", {16'd0, wlog_a[(base_w + i) % 16]}, {16'd0, e_a[i]});
            chk(rq, "write data", {24'd0, wlog_d[(base_w + i) % 16]}, {24'd0, e_d[i]});
        end
        if (chk_res) chk(rq, "pull_data", {16'd0, pull_data}, {16'd0, exp_res});
        if (chk_st)  chk(rq, "status_out", {24'd0, status_out}, {24'd0, exp_st});
        base_a = acc;
        @(negedge clk);
        chk("R11", "done width", {31'd0, done}, 32'd0);
        chk("R12", "no extra access", acc - base_a, 0);
        chk("R12", "sp after idle", {16'd0, sp}, {16'd0, exp_sp});
    endtask

    task automatic run_bad(input logic [2:0] o);
        int base_a;
        @(negedge clk);
        base_a = acc;
        start = 1'b1; op_i = o;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12", "undefined op access", acc - base_a, 0);
        chk("R12", "undefined op sp", {16'd0, sp}, {16'd0, exp_sp});
        chk("R12", "undefined op busy", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic [2:0] o;
        logic leg;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sp", {16'd0, sp}, 32'h01FF);
        chk("R1", "busy", {31'd0, busy}, 0);
        chk("R1", "done", {31'd0, done}, 0);
        chk("R1", "mem_req", {31'd0, mem_req}, 0);
        rst_n = 1'b1;

        run_op("R2", 3'd0, 1'b1, 16'h00A5, '0, '0, '0, '0, 1'b0);
        run_op("R3", 3'd1, 1'b1, '0, '0, '0, '0, '0, 1'b0);
        run_op("R5", 3'd1, 1'b1, '0, '0, '0, '0, '0, 1'b0);   // 01FF -> 0100
        run_op("R5", 3'd0, 1'b1, 16'h005A, '0, '0, '0, '0, 1'b0); // 0100 -> 01FF
        run_op("R4", 3'd2, 1'b1, 16'h1234, '0, '0, '0, '0, 1'b1);
        run_op("R4", 3'd3, 1'b1, '0, '0, '0, '0, '0, 1'b0);
        run_bad(3'd6);
        run_bad(3'd7);
        run_op("R10", 3'd0, 1'b1, 16'h0000, '0, '0, '0, '0, 1'b0);
        run_op("R10", 3'd4, 1'b1, '0, '0, '0, '0, '0, 1'b0);
        run_op("R10", 3'd0, 1'b0, 16'h0000, '0, '0, '0, '0, 1'b0);
        run_op("R10", 3'd4, 1'b0, '0, '0, '0, '0, '0, 1'b0);
        run_op("R7", 3'd5, 1'b1, '0, 16'h8123, 8'h7E, 8'h0B, 16'h0810, 1'b1);
        run_op("R8", 3'd5, 1'b0, '0, 16'hFFFF, 8'hC3, 8'h88, 16'h08F0, 1'b0);
        run_op("R9", 3'd5, 1'b0, '0, 16'h4000, 8'h01, 8'h00, 16'h0822, 1'b0);
        // R6 native page crossing: reach 0x0100 with a legacy pull
        run_op("R5", 3'd3, 1'b1, '0, '0, '0, '0, '0, 1'b0);
        while (exp_sp != 16'h01FF) run_op("R3", 3'd1, 1'b1, '0, '0, '0, '0, '0, 1'b0);
        run_op("R5", 3'd1, 1'b1, '0, '0, '0, '0, '0, 1'b0);
        run_op("R6", 3'd0, 1'b0, 16'h0077, '0, '0, '0, '0, 1'b0);
        chk("R6", "sp crossed page", {16'd0, sp}, 32'h00FF);
        run_op("R6", 3'd2, 1'b0, 16'hBEEF, '0, '0, '0, '0, 1'b0);
        run_op("R6", 3'd3, 1'b0, '0, '0, '0, '0, '0, 1'b0);
        run_op("R6", 3'd1, 1'b0, '0, '0, '0, '0, '0, 1'b0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            o = 3'($urandom % 6);
            leg = ($urandom % 3) == 0;
            if (!leg && exp_sp < 16'h0040 && (o == 3'd0 || o == 3'd2 || o == 3'd5)) o = 3'd3;
            if (!leg && exp_sp > 16'h0600 && (o == 3'd1 || o == 3'd3 || o == 3'd4)) o = 3'd2;
            run_op(o == 3'd5 ? (leg ? "R7" : "R8") : (leg ? "R5" : "R4"),
                   o, leg, 16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                   16'h0800 + 16'($urandom % 255), ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule